// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking page tables kept in memory. A walk starts with a fetch from a context table, selected by a root pointer and a context number. It then descends through up to three levels of tables, one fetch per level. The walk stops at the first leaf entry. A leaf found at level 1 maps a 16 MB region, a leaf at level 2 maps 256 KB, and a leaf at level 3 maps a 4 KB page.

All fetches go through one memory port. The port has a single outstanding request, carries a read-or-write flag and returns an error flag with each response. When a leaf's referenced or modified flag must change, the walker writes the updated leaf back to the address it was fetched from before it reports completion. A failed walk ends with a fault code that carries both the level where the walk stopped and the kind of fault.

A requester pulses `start_i` with the address, the access kind, the root pointer and the context number. It then waits for the one-cycle `done_o` pulse. The results stay on the outputs until the next walk completes.

Top module: `pt_walker`

## Requirements
- R1: The first fetch of a walk reads address `{root_ptr_i, 4'b0} + {ctx_i, 2'b00}`, the context table entry (level 0).
- R2: Bits [1:0] of each fetched entry give its type: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. A table pointer at level 0, 1 or 2 makes the walker fetch the next level.
- R3: A next-level fetch reads `{entry[31:2], 6'b0} + {index, 2'b00}`. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R4: A leaf at level 1, 2 or 3 ends the walk without a fault. `page_size_o` is 2 (16 MB), 1 (256 KB) or 0 (4 KB) for those levels. `paddr_o` is `{leaf[31:8], 12'b0}` plus an offset: VA[23:12] shifted left by 12 at level 1, VA[17:12] shifted left by 12 at level 2, and zero at level 3.
- R5: A failed walk raises `fault_o` with `done_o`. `fault_code_o[9:8]` holds the level (0 to 3) of the entry that stopped the walk, `fault_code_o[4:2]` holds the fault type, and all other bits are zero. An invalid entry gives type 1.
- R6: Fault type 4 is reported for four cases: a fetch that returns `mem_err_i`, a reserved entry, a leaf at level 0, and a table pointer at level 3.
- R7: Bit 5 of a leaf is its referenced flag. If that flag is clear, the walker writes the leaf back to its fetch address with bit 5 set before it raises `done_o`. No write is issued otherwise (see R8 for writes).
- R8: Bit 6 of a leaf is its modified flag. On a write walk (`write_i`=1) with bit 6 clear, the write-back also sets bit 6. `leaf_o` reports the leaf as it was written back. `wr_ok_o` equals bit 6 of `leaf_o`, so a read of a clean page reports no write permission.
- R9: `done_o` is a one-cycle pulse, raised on the same cycle that `busy_o` falls. The results hold until the next walk completes. A `start_i` seen while busy is ignored.
- R10: Each memory request is a one-cycle `mem_req_o` pulse. The next request comes only after `mem_ack_i` for the previous one.
- R11: While `rst_ni` is low, the walker is idle and `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk; taken only when idle |
| vaddr_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | The access is a write |
| root_ptr_i | input | 32 | Context table pointer (physical address bits [35:4]) |
| ctx_i | input | CTX_W | Context number |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse when a walk finishes |
| fault_o | output | 1 | The last walk faulted |
| fault_code_o | output | 10 | Level in [9:8], fault type in [4:2] |
| paddr_o | output | 36 | Translated physical address |
| page_size_o | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| leaf_o | output | 32 | Leaf entry after any flag update |
| wr_ok_o | output | 1 | Write permission (modified flag set) |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | The request is a write-back |
| mem_addr_o | output | 36 | Memory address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Memory response |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Bus error with the response |

## Verification
The assertions assume that the memory port answers each request with exactly one `mem_ack_i`, never acknowledges when nothing is outstanding, and never acknowledges on the same cycle as the request. The bench memory model meets these assumptions: it acknowledges only requests it has taken, always after a fixed delay of two cycles. It also raises an error only on a response to the one address the bench chooses. Table contents are written only while the walker is idle, so no entry changes during a walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } ent_type_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WB_REQ, S_WB_WAIT
  } walk_st_e;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;
  localparam logic [1:0] PG_4K   = 2'd0;
  localparam logic [1:0] PG_256K = 2'd1;
  localparam logic [1:0] PG_16M  = 2'd2;
endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walk_pkg::*;
(
  input  logic [31:0] entry_i,
  input  logic [1:0]  lvl_i,
  input  logic        bus_err_i,
  output logic        descend_o,
  output logic        leaf_o,
  output logic        fault_o,
  output logic [2:0]  ftype_o
);
  always_comb begin
    descend_o = 1'b0;
    leaf_o    = 1'b0;
    fault_o   = 1'b0;
    ftype_o   = 3'd0;
    if (bus_err_i) begin
      fault_o = 1'b1;
      ftype_o = FT_XLATE;
    end else begin
      unique case (ent_type_e'(entry_i[1:0]))
        ET_INVALID: begin fault_o = 1'b1; ftype_o = FT_INVALID; end
        ET_TABLE: begin
          if (lvl_i == 2'd3) begin fault_o = 1'b1; ftype_o = FT_XLATE; end
          else descend_o = 1'b1;
        end
        ET_LEAF: begin
          if (lvl_i == 2'd0) begin fault_o = 1'b1; ftype_o = FT_XLATE; end
          else leaf_o = 1'b1;
        end
        default: begin fault_o = 1'b1; ftype_o = FT_XLATE; end
      endcase
    end
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int CTX_W = 8,
  parameter int PA_W  = 36
) (
  input  logic [1:0]       lvl_i,
  input  logic [31:0]      root_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [31:0]      desc_i,
  input  logic [31:0]      va_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [7:0]      idx;
  logic [PA_W-1:0] base;

  always_comb begin
    unique case (lvl_i)
      2'd1:    idx = va_i[31:24];
      2'd2:    idx = {2'b00, va_i[23:18]};
      2'd3:    idx = {2'b00, va_i[17:12]};
      default: idx = 8'd0;
    endcase
    if (lvl_i == 2'd0)
      addr_o = PA_W'({root_i, 4'b0000}) + PA_W'({ctx_i, 2'b00});
    else begin
      base   = PA_W'({desc_i[31:2], 6'b000000});
      addr_o = base + PA_W'({idx, 2'b00});
    end
  end
endmodule

// File: rtl/pt_pa_form.sv
module pt_pa_form
  import pt_walk_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [31:0]     leaf_i,
  input  logic [1:0]      lvl_i,
  input  logic [31:0]     va_i,
  output logic [PA_W-1:0] paddr_o,
  output logic [1:0]      size_o
);
  logic [PA_W-1:0] off;

  always_comb begin
    unique case (lvl_i)
      2'd1:    begin off = PA_W'({va_i[23:12], 12'h000}); size_o = PG_16M;  end
      2'd2:    begin off = PA_W'({va_i[17:12], 12'h000}); size_o = PG_256K; end
      default: begin off = '0;                            size_o = PG_4K;   end
    endcase
    paddr_o = PA_W'({leaf_i[31:8], 12'h000}) + off;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter  int CTX_W = 8,
  localparam int PA_W  = 36,
  localparam int FC_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      vaddr_i,
  input  logic             write_i,
  input  logic [31:0]      root_ptr_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [FC_W-1:0]  fault_code_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       page_size_o,
  output logic [31:0]      leaf_o,
  output logic             wr_ok_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_err_i
);
  walk_st_e         st_q;
  logic [1:0]       lvl_q;
  logic [31:0]      va_q, root_q, desc_q, leaf_q;
  logic             we_q, done_q, fault_q, wr_ok_q;
  logic [CTX_W-1:0] ctx_q;
  logic [PA_W-1:0]  fetch_addr_q, paddr_q, gen_addr, pa_next;
  logic [FC_W-1:0]  code_q;
  logic [1:0]       size_q, size_next;
  logic             dec_desc, dec_leaf, dec_fault;
  logic [2:0]       dec_ftype;
  logic [31:0]      leaf_upd;
  logic             need_wb;

  pt_addr_gen #(.CTX_W(CTX_W), .PA_W(PA_W)) u_addr (
    .lvl_i(lvl_q), .root_i(root_q), .ctx_i(ctx_q), .desc_i(desc_q),
    .va_i(va_q), .addr_o(gen_addr)
  );

  pt_entry_decode u_dec (
    .entry_i(mem_rdata_i), .lvl_i(lvl_q), .bus_err_i(mem_err_i),
    .descend_o(dec_desc), .leaf_o(dec_leaf), .fault_o(dec_fault),
    .ftype_o(dec_ftype)
  );

  pt_pa_form #(.PA_W(PA_W)) u_pa (
    .leaf_i(mem_rdata_i), .lvl_i(lvl_q), .va_i(va_q),
    .paddr_o(pa_next), .size_o(size_next)
  );

  always_comb begin
    leaf_upd = mem_rdata_i;
    leaf_upd[REF_BIT] = 1'b1;
    if (we_q) leaf_upd[MOD_BIT] = 1'b1;
    need_wb = !mem_rdata_i[REF_BIT] || (we_q && !mem_rdata_i[MOD_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      lvl_q <= '0; va_q <= '0; root_q <= '0; desc_q <= '0; leaf_q <= '0;
      we_q <= 1'b0; done_q <= 1'b0; fault_q <= 1'b0; wr_ok_q <= 1'b0;
      ctx_q <= '0; fetch_addr_q <= '0; paddr_q <= '0; code_q <= '0;
      size_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          va_q <= vaddr_i; we_q <= write_i; root_q <= root_ptr_i;
          ctx_q <= ctx_i; lvl_q <= 2'd0;
          st_q <= S_RD_REQ;
        end
        S_RD_REQ: begin
          fetch_addr_q <= gen_addr;
          st_q <= S_RD_WAIT;
        end
        S_RD_WAIT: if (mem_ack_i) begin
          if (dec_fault) begin
            fault_q <= 1'b1;
            code_q  <= {lvl_q, 3'b000, dec_ftype, 2'b00};
            done_q  <= 1'b1;
            st_q    <= S_IDLE;
          end else if (dec_desc) begin
            desc_q <= mem_rdata_i;
            lvl_q  <= lvl_q + 2'd1;
            st_q   <= S_RD_REQ;
          end else if (dec_leaf) begin
            fault_q <= 1'b0;
            code_q  <= '0;
            leaf_q  <= leaf_upd;
            wr_ok_q <= leaf_upd[MOD_BIT];
            paddr_q <= pa_next;
            size_q  <= size_next;
            if (need_wb) st_q <= S_WB_REQ;
            else begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end
          end
        end
        S_WB_REQ: st_q <= S_WB_WAIT;
        S_WB_WAIT: if (mem_ack_i) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign paddr_o      = paddr_q;
  assign page_size_o  = size_q;
  assign leaf_o       = leaf_q;
  assign wr_ok_o      = wr_ok_q;
  assign mem_req_o    = (st_q == S_RD_REQ) || (st_q == S_WB_REQ);
  assign mem_we_o     = (st_q == S_WB_REQ);
  assign mem_addr_o   = (st_q == S_WB_REQ) ? fetch_addr_q : gen_addr;
  assign mem_wdata_o  = leaf_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [9:0]  fault_code_o,
  input logic [1:0]  page_size_o,
  input logic        wr_ok_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i
);
  logic outstanding_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding_q <= 1'b0;
    else if (mem_req_o) outstanding_q <= 1'b1;
    else if (mem_ack_i) outstanding_q <= 1'b0;
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outstanding_q);
  p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_req_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  p_wb_ref_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[5] && mem_wdata_o[1:0] == 2'd2));
  p_wb_mod_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[6] == wr_ok_o));
  p_fault_type_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |->
      ((fault_code_o[4:2] == 3'd1 || fault_code_o[4:2] == 3'd4) &&
       fault_code_o[7:5] == 3'd0 && fault_code_o[1:0] == 2'd0));
  p_size_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (page_size_o != 2'd3));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .fault_o(fault_o), .fault_code_o(fault_code_o), .page_size_o(page_size_o),
  .wr_ok_o(wr_ok_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic        wr = 1'b0;
  logic [31:0] root = 32'h0000_1000;
  logic [7:0]  ctx = 8'd3;
  logic        busy, done, fault, wr_ok;
  logic [9:0]  code;
  logic [35:0] paddr, maddr;
  logic [1:0]  psize;
  logic [31:0] leaf, wdata, rdata;
  logic        req, we, ack, err;

  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  pt_walker #(.CTX_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vaddr_i(va), .write_i(wr),
    .root_ptr_i(root), .ctx_i(ctx), .busy_o(busy), .done_o(done),
    .fault_o(fault), .fault_code_o(code), .paddr_o(paddr),
    .page_size_o(psize), .leaf_o(leaf), .wr_ok_o(wr_ok), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_ack_i(ack),
    .mem_rdata_i(rdata), .mem_err_i(err)
  );

  // memory model: fixed two-cycle latency
  logic [31:0] mem [logic [35:0]];
  logic [35:0] rd_log [8];
  int          rd_n = 0, wr_n = 0;
  logic [35:0] wr_addr;
  logic [35:0] err_addr = '1;
  logic        pend = 1'b0, p_we = 1'b0;
  logic [35:0] p_addr;
  logic [31:0] p_data;
  int          p_cnt = 0;

  initial begin ack = 1'b0; err = 1'b0; rdata = '0; end

  always @(posedge clk) begin
    ack <= 1'b0;
    err <= 1'b0;
    if (req) begin
      pend = 1'b1; p_we = we; p_addr = maddr; p_data = wdata; p_cnt = 1;
      if (we) begin wr_n++; wr_addr = maddr; end
      else begin
        if (rd_n < 8) rd_log[rd_n] = maddr;
        rd_n++;
      end
    end else if (pend) begin
      if (p_cnt == 0) begin
        pend = 1'b0;
        ack <= 1'b1;
        if (p_we) mem[p_addr] = p_data;
        else begin
          rdata <= mem.exists(p_addr) ? mem[p_addr] : 32'h0;
          err   <= (p_addr == err_addr);
        end
      end else p_cnt--;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_desc(input logic [35:0] pa);
    return pa[35:4] | 32'h1;
  endfunction

  // run one walk; optional second start while busy
  task automatic walk(input logic [31:0] v, input logic w, input logic [7:0] c,
                      input bit poke);
    int n = 0;
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    va = v; wr = w; ctx = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      va = 32'h1288_5000; wr = 1'b1; ctx = 8'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done, "R9", "walk finished", {63'd0, done}, 64'd1);
    chk(!busy, "R9", "idle with done", {63'd0, busy}, 64'd0);
  endtask

  task automatic expect_fault(input logic [9:0] exp, input string rq);
    chk(fault, rq, "fault flag", {63'd0, fault}, 64'd1);
    chk(code == exp, rq, "fault code", {54'd0, code}, {54'd0, exp});
    chk(wr_n == 0, rq, "no write on fault", wr_n, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fault && !req, "R11", "reset idle",
        {60'd0, busy, done, fault, req}, 64'd0);
  endtask

  task automatic t_l3_read;
    mem[36'h1000C] = mk_desc(36'h20000);
    mem[36'h20048] = mk_desc(36'h30000);
    mem[36'h30034] = mk_desc(36'h40000);
    mem[36'h40014] = 32'h5678_9A02;
    walk(32'h1234_5678, 1'b0, 8'd3, 0);
    chk(rd_log[0] == 36'h1000C, "R1", "context fetch addr", rd_log[0], 36'h1000C);
    chk(rd_log[1] == 36'h20048, "R3", "level1 addr", rd_log[1], 36'h20048);
    chk(rd_log[2] == 36'h30034, "R3", "level2 addr", rd_log[2], 36'h30034);
    chk(rd_log[3] == 36'h40014, "R2", "level3 addr", rd_log[3], 36'h40014);
    chk(!fault, "R4", "no fault", {63'd0, fault}, 0);
    chk(paddr == 36'h5_6789_A000, "R4", "4K paddr", paddr, 36'h5_6789_A000);
    chk(psize == 2'd0, "R4", "4K size", psize, 0);
    chk(wr_n == 1 && wr_addr == 36'h40014, "R7", "ref write-back", wr_addr, 36'h40014);
    chk(mem[36'h40014] == 32'h5678_9A22, "R7", "ref bit stored", mem[36'h40014], 32'h5678_9A22);
    chk(leaf == 32'h5678_9A22, "R8", "leaf out", leaf, 32'h5678_9A22);
    chk(!wr_ok, "R8", "clean read no write perm", {63'd0, wr_ok}, 0);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", {63'd0, done}, 0);
    chk(paddr == 36'h5_6789_A000, "R9", "result held", paddr, 36'h5_6789_A000);
  endtask

  task automatic t_l1_leaf(input bit poke);
    mem[36'h201FC] = 32'h1200_0062;
    walk(32'h7FAB_C123, 1'b0, 8'd3, poke);
    chk(rd_n == 2, poke ? "R9" : "R4", "two reads", rd_n, 2);
    chk(!fault, "R4", "no fault", {63'd0, fault}, 0);
    chk(paddr == 36'h1_20AB_C000, "R4", "16M paddr", paddr, 36'h1_20AB_C000);
    chk(psize == 2'd2, "R4", "16M size", psize, 2);
    chk(wr_n == 0, "R7", "no write when flags set", wr_n, 0);
    chk(wr_ok, "R8", "dirty page write perm", {63'd0, wr_ok}, 1);
  endtask

  task automatic t_l2_write;
    mem[36'h30088] = 32'h3000_0002;
    walk(32'h1288_5000, 1'b1, 8'd3, 0);
    chk(paddr == 36'h3_0000_5000, "R4", "256K paddr", paddr, 36'h3_0000_5000);
    chk(psize == 2'd1, "R4", "256K size", psize, 1);
    chk(wr_n == 1 && mem[36'h30088] == 32'h3000_0062, "R8", "mod write-back",
        mem[36'h30088], 32'h3000_0062);
    chk(wr_ok, "R8", "write perm after update", {63'd0, wr_ok}, 1);
  endtask

  task automatic t_faults;
    walk(32'h1290_0000, 1'b0, 8'd3, 0);
    expect_fault(10'h204, "R5");
    mem[36'h200CC] = 32'h3;
    walk(32'h3300_0000, 1'b0, 8'd3, 0);
    expect_fault(10'h110, "R6");
    mem[36'h10014] = 32'h2;
    walk(32'h0, 1'b0, 8'd5, 0);
    expect_fault(10'h010, "R6");
    walk(32'h0, 1'b0, 8'd6, 0);
    expect_fault(10'h004, "R5");
    err_addr = 36'h40014;
    walk(32'h1234_5678, 1'b0, 8'd3, 0);
    expect_fault(10'h310, "R6");
    err_addr = '1;
    mem[36'h40018] = 32'h5001;
    walk(32'h1234_6678, 1'b0, 8'd3, 0);
    expect_fault(10'h310, "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_l3_read();
    t_l1_leaf(0);
    t_l2_write();
    t_faults();
    t_l1_leaf(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule